// File: doc/BRIEF.md
# Serial Configuration Register Port

This block lets an external host read and write a small bank of 24-bit configuration registers over four wires: a frame-select line, a serial clock, a host-to-slave data line and a slave-to-host data line. Every transaction is a fixed frame of 32 serial clocks. The first bit picks the direction. Six address bits come next, most significant first. The last 24 bits are the data word, most significant first. A write becomes visible on the parallel register output only when a complete frame closes. A read frame sends the addressed word back on the return line.

All four serial wires are treated as ordinary asynchronous inputs. Each one passes through a two-flop synchronizer into the system clock domain, which must run at least four times faster than the serial clock. Edges of the serial clock are found by comparing successive synchronized samples. The register contents drive a flat output bus for the rest of the chip. Addresses listed in a read-only mask cannot be written, and reading them returns a status word supplied by the chip. Addresses at or beyond the bank size read as zero.

Top module: `serial_reg_port`

## Requirements
- R1: Inside a frame, rising edge 1 carries the direction bit (0 = write, 1 = read). Rising edges 2 to 7 carry the address, MSB first. Rising edges 8 to 31 carry the data word, MSB first. Rising edge 32 carries no information.
- R2: A write frame updates register `addr`, seen at `cfg_regs[addr*24 +: 24]`, after the select line drops. The select line drops together with the 32nd falling edge.
- R3: A frame that holds any count of rising edges other than exactly 32 before the select line drops changes no register.
- R4: In a read frame, `host_sdo` carries the addressed word MSB first. Each bit is valid at falling edges 8 to 31 of the serial clock, so bit 23 is sampled at falling edge 8.
- R5: A read frame changes no register, whatever data bits the host sends.
- R6: Addresses at or above NUM_REGS read as zero, and writes to them change no register.
- R7: An address whose bit is set in RO_MASK (by default address 7 only) ignores writes. Its slot on `cfg_regs` stays zero, and reading it returns `status_word`.
- R8: After reset every register is zero and `host_sdo` is low.
- R9: `host_sdo` stays low during write frames and while the select line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Frame select from host, high during a frame |
| host_sclk | input | 1 | Serial clock from host, idles low |
| host_sdi | input | 1 | Serial data from host, sampled on rising edges |
| host_sdo | output | 1 | Serial read data to host, changes after falling edges |
| status_word | input | 24 | Value returned for read-only addresses |
| cfg_regs | output | NUM_REGS*24 | All registers, slot i at bits i*24 +: 24 |

## Verification
Two events share one system cycle: the end of a frame, when the write is committed, and the last falling edge of the serial clock. Both pass through synchronizers of equal depth, so they are detected together. A frame cut short by a single clock drops the select line at falling edge 31 instead of 32. The bench provokes both cases by dropping the select line in the same instant as the last falling edge. It judges them through `cfg_regs` and by read-back. It also starts a read of the same register after a gap of only four system clocks, to show that the new value is already in place when the next frame latches its address.

// File: rtl/srp_pkg.sv
`timescale 1ns/1ps
// Package: frame geometry shared by the serial register port.
// Assumes a fixed 1 + 6 + 24 bit frame closed by a 32nd clock.
package srp_pkg;
    localparam int ADDR_BITS  = 6;
    localparam int DATA_BITS  = 24;
    localparam int FRAME_CLKS = 32;
    localparam int SHIFT_BITS = 1 + ADDR_BITS + DATA_BITS;  // 31 payload bits
    localparam int CNT_W      = 6;
    localparam int ADDR_DONE  = 1 + ADDR_BITS;               // edge count when address complete
endpackage

// File: rtl/srp_sync.sv
`timescale 1ns/1ps
// Module: srp_sync
// Two-flop synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is independent (no multi-bit coherency needed).
module srp_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages per bit toward the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/srp_frame.sv
`timescale 1ns/1ps
// Module: srp_frame
// Recovers serial clock edges from synchronized samples, counts rising
// edges, shifts in the 31 payload bits and shifts out read data.
// Assumes the system clock is at least 4x the serial clock, and that select,
// clock and data all reach this block through synchronizers of equal depth.
module srp_frame
    import srp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_s,
    input  logic                 sel_s,
    input  logic                 sdi_s,
    input  logic [DATA_BITS-1:0] rd_word,
    output logic [ADDR_BITS-1:0] rd_addr,
    output logic                 wr_commit,
    output logic [ADDR_BITS-1:0] wr_addr,
    output logic [DATA_BITS-1:0] wr_data,
    output logic                 sdo,
    output logic [CNT_W-1:0]     edge_cnt
);
    logic                  sclk_d, sel_d;
    logic                  rise, fall, sel_drop;
    logic [SHIFT_BITS-1:0] in_sh;
    logic [DATA_BITS-1:0]  out_sh;

    assign rise     = sclk_s & ~sclk_d;
    assign fall     = ~sclk_s & sclk_d;
    assign sel_drop = sel_d & ~sel_s;

    // Delay copies used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            sel_d  <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            sel_d  <= sel_s;
        end
    end

    // Rising-edge counter, cleared outside a frame, saturating at its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel_s)
            edge_cnt <= '0;
        else if (rise && edge_cnt != '1)
            edge_cnt <= edge_cnt + 1'b1;
    end

    // Payload shift register: only rising edges 1..31 carry bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_sh <= '0;
        else if (sel_s && rise && edge_cnt < CNT_W'(SHIFT_BITS))
            in_sh <= {in_sh[SHIFT_BITS-2:0], sdi_s};
    end

    assign rd_addr = in_sh[ADDR_BITS-1:0];

    // Read data: loaded once the address is complete, advanced on falls 8..30.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel_s)
            out_sh <= '0;
        else if (edge_cnt == CNT_W'(ADDR_DONE))
            out_sh <= in_sh[ADDR_BITS] ? rd_word : '0;
        else if (fall && edge_cnt > CNT_W'(ADDR_DONE) && edge_cnt < CNT_W'(SHIFT_BITS))
            out_sh <= {out_sh[DATA_BITS-2:0], 1'b0};
    end

    assign sdo = out_sh[DATA_BITS-1];

    // Commit a write only when a complete frame closes.
    assign wr_commit = sel_drop && (edge_cnt == CNT_W'(FRAME_CLKS)) && !in_sh[SHIFT_BITS-1];
    assign wr_addr   = in_sh[SHIFT_BITS-2 -: ADDR_BITS];
    assign wr_data   = in_sh[DATA_BITS-1:0];
endmodule

// File: rtl/srp_bank.sv
`timescale 1ns/1ps
// Module: srp_bank
// Register storage with a read multiplexer. Read-only slots return a status
// word and ignore writes. Addresses at or beyond NUM_REGS read as zero.
// Assumes NUM_REGS <= 64 so that every slot is reachable with a 6-bit address.
module srp_bank
    import srp_pkg::*;
#(
    parameter int               NUM_REGS = 8,
    parameter logic [NUM_REGS-1:0] RO_MASK = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_BITS-1:0]          wr_addr,
    input  logic [DATA_BITS-1:0]          wr_data,
    input  logic [ADDR_BITS-1:0]          rd_addr,
    input  logic [DATA_BITS-1:0]          status_word,
    output logic [DATA_BITS-1:0]          rd_word,
    output logic [NUM_REGS*DATA_BITS-1:0] cfg_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        if (RO_MASK[i]) begin : g_ro
            assign cfg_flat[i*DATA_BITS +: DATA_BITS] = '0;
        end else begin : g_rw
            logic [DATA_BITS-1:0] q;
            // Writable slot: loads on a committed write to its address.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && wr_addr == ADDR_BITS'(i))
                    q <= wr_data;
            end
            assign cfg_flat[i*DATA_BITS +: DATA_BITS] = q;
        end
    end

    // Read selection; unmatched addresses fall through to zero.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_BITS'(i))
                rd_word = RO_MASK[i] ? status_word : cfg_flat[i*DATA_BITS +: DATA_BITS];
        end
    end
endmodule

// File: rtl/serial_reg_port.sv
`timescale 1ns/1ps
// Module: serial_reg_port (top)
// Serial slave for a 24-bit configuration bank. Each frame is 32 serial clocks:
// a direction bit, a 6-bit address and a 24-bit word. Serial inputs are
// oversampled by clk through two-flop synchronizers.
// Assumes clk is at least 4x host_sclk and host_sclk idles low.
module serial_reg_port
    import srp_pkg::*;
#(
    parameter int                  NUM_REGS = 8,
    parameter logic [NUM_REGS-1:0] RO_MASK  = NUM_REGS'(1) << (NUM_REGS - 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_sel,
    input  logic                          host_sclk,
    input  logic                          host_sdi,
    output logic                          host_sdo,
    input  logic [DATA_BITS-1:0]          status_word,
    output logic [NUM_REGS*DATA_BITS-1:0] cfg_regs
);
    logic                 sel_s, sclk_s, sdi_s;
    logic [ADDR_BITS-1:0] rd_addr, wr_addr;
    logic [DATA_BITS-1:0] rd_word, wr_data;
    logic                 wr_commit;
    logic [CNT_W-1:0]     edge_cnt;

    srp_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({host_sel, host_sclk, host_sdi}),
        .q     ({sel_s, sclk_s, sdi_s})
    );

    srp_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .sel_s     (sel_s),
        .sdi_s     (sdi_s),
        .rd_word   (rd_word),
        .rd_addr   (rd_addr),
        .wr_commit (wr_commit),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sdo       (host_sdo),
        .edge_cnt  (edge_cnt)
    );

    srp_bank #(.NUM_REGS(NUM_REGS), .RO_MASK(RO_MASK)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_commit),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .status_word (status_word),
        .rd_word     (rd_word),
        .cfg_flat    (cfg_regs)
    );
endmodule

// File: rtl/serial_reg_port_chk.sv
`timescale 1ns/1ps
// Module: serial_reg_port_chk
// Timing properties of the serial register port, bound into the top.
module serial_reg_port_chk #(
    parameter int NUM_REGS = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sel_s,
    input logic [5:0]             edge_cnt,
    input logic                   wr_commit,
    input logic                   host_sdo,
    input logic [NUM_REGS*24-1:0] cfg_regs
);
    // R9: return line is low once the synchronized select is low
    a_r9_sdo_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |=> !host_sdo);

    // R2/R5: the register bus moves only after a commit
    a_r2_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_commit |=> $stable(cfg_regs));

    // R2: a commit coincides with the select line going low
    a_r2_commit_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> (!sel_s && $past(sel_s)));

    // R3: edge count restarts between frames
    a_r3_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |=> edge_cnt == 6'd0);
endmodule

bind serial_reg_port serial_reg_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_s     (sel_s),
    .edge_cnt  (edge_cnt),
    .wr_commit (wr_commit),
    .host_sdo  (host_sdo),
    .cfg_regs  (cfg_regs)
);

// File: tb/tb_serial_reg_port.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module tb_serial_reg_port;
    localparam int NR   = 8;
    localparam int HALF = 40;   // serial half period, 8 system clocks

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_sel = 1'b0, host_sclk = 1'b0, host_sdi = 1'b0;
    logic              host_sdo;
    logic [23:0]       status_word = 24'h5A0F3C;
    logic [NR*24-1:0]  cfg_regs;

    int total = 0;
    int bad   = 0;
    logic [23:0] model [NR];

    always #2.5 clk = ~clk;

    serial_reg_port dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_sclk(host_sclk),
        .host_sdi(host_sdi), .host_sdo(host_sdo), .status_word(status_word),
        .cfg_regs(cfg_regs)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic frame_bit(input logic rw, input logic [5:0] a,
                                       input logic [23:0] d, input int k);
        if (k == 1) return rw;
        if (k >= 2 && k <= 7) return a[7-k];
        if (k >= 8 && k <= 31) return d[31-k];
        return 1'b0;
    endfunction

    // Frame with nclk serial clocks; select drops with the last falling edge.
    task automatic frame(input logic rw, input logic [5:0] a, input logic [23:0] d,
                         input int nclk, input int gap, output logic [23:0] rdata);
        rdata = '0;
        @(negedge clk);
        host_sel = 1'b1;
        host_sdi = frame_bit(rw, a, d, 1);
        #HALF;
        for (int k = 1; k <= nclk; k++) begin
            host_sclk = 1'b1;
            #HALF;
            if (k >= 8 && k <= 31) rdata[31-k] = host_sdo;
            host_sclk = 1'b0;
            if (k == nclk) host_sel = 1'b0;
            host_sdi = frame_bit(rw, a, d, k + 1);
            #HALF;
        end
        host_sel = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NR; i++) check(req, cfg_regs[i*24 +: 24], model[i]);
    endtask

    task automatic t_reset;
        for (int i = 0; i < NR; i++) model[i] = '0;
        check_bank("R8 reset register");
        check("R8 sdo after reset", {23'd0, host_sdo}, 24'd0);
    endtask

    task automatic t_write_read;
        logic [23:0] r;
        frame(1'b0, 6'd2, 24'hA5C396, 32, 12, r);
        model[2] = 24'hA5C396;
        check("R9 sdo low in write frame", r, 24'd0);
        check_bank("R1 R2 write slot 2");
        frame(1'b1, 6'd2, 24'hFFFFFF, 32, 12, r);
        check("R4 read back slot 2", r, 24'hA5C396);
        check_bank("R5 read leaves bank");
        check("R9 sdo low after frame", {23'd0, host_sdo}, 24'd0);
    endtask

    task automatic t_patterns;
        logic [23:0] r;
        frame(1'b0, 6'd0, 24'h800001, 32, 12, r); model[0] = 24'h800001;
        frame(1'b0, 6'd1, 24'h0F0F0F, 32, 12, r); model[1] = 24'h0F0F0F;
        frame(1'b0, 6'd5, 24'hFFFFFF, 32, 12, r); model[5] = 24'hFFFFFF;
        frame(1'b0, 6'd6, 24'h123456, 32, 12, r); model[6] = 24'h123456;
        check_bank("R1 R2 several slots");
        frame(1'b1, 6'd0, 24'h0, 32, 12, r); check("R4 read slot 0", r, model[0]);
        frame(1'b1, 6'd1, 24'h0, 32, 12, r); check("R4 read slot 1", r, model[1]);
        frame(1'b1, 6'd6, 24'h0, 32, 12, r); check("R4 read slot 6", r, model[6]);
    endtask

    task automatic t_bad_length;
        logic [23:0] r;
        frame(1'b0, 6'd3, 24'hDEAD01, 31, 12, r);
        check_bank("R3 frame of 31 clocks");
        frame(1'b0, 6'd3, 24'hDEAD02, 20, 12, r);
        check_bank("R3 frame of 20 clocks");
        frame(1'b0, 6'd3, 24'hDEAD03, 33, 12, r);
        check_bank("R3 frame of 33 clocks");
    endtask

    task automatic t_read_only;
        logic [23:0] r;
        frame(1'b0, 6'd7, 24'h777777, 32, 12, r);
        check_bank("R7 write to read-only slot");
        frame(1'b1, 6'd7, 24'h0, 32, 12, r);
        check("R7 read status word", r, 24'h5A0F3C);
    endtask

    task automatic t_unimplemented;
        logic [23:0] r;
        frame(1'b0, 6'd40, 24'h654321, 32, 12, r);
        check_bank("R6 write above bank");
        frame(1'b1, 6'd40, 24'h0, 32, 12, r);
        check("R6 read above bank", r, 24'd0);
        frame(1'b1, 6'd8, 24'h0, 32, 12, r);
        check("R6 read first missing address", r, 24'd0);
    endtask

    task automatic t_back_to_back;
        logic [23:0] r;
        frame(1'b0, 6'd4, 24'hC0FFEE, 32, 4, r);
        model[4] = 24'hC0FFEE;
        frame(1'b1, 6'd4, 24'h0, 32, 12, r);
        check("R2 read right after commit", r, 24'hC0FFEE);
        check_bank("R2 back to back");
    endtask

    initial begin
        #500000;
        total++; bad++;
        $display("FAIL watchdog actual=%h expected=%h", 24'd1, 24'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_write_read();
        t_patterns();
        t_bad_length();
        t_read_only();
        t_unimplemented();
        t_back_to_back();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule